// File: doc/BRIEF.md
# Debug halt request handshake controller

This block sequences a processor core into a halted debug state in answer to an external halt request. While the core runs, it counts the memory accesses that the core has issued and that have not yet completed. When a halt request arrives, the block stops new accesses from being issued and enters a drain phase. In that phase a synchronization barrier waits for the outstanding count to reach zero. When the barrier completes, the core is halted. The acknowledge output and the done output both rise, which tells the system that every later memory access comes from debugger activity.

A debug status register records how debug state was entered. It carries a 4-bit entry-method code in bits [5:2], a read-only halted flag in bit 0, and a debugger-writable acknowledge bit in bit 10. Setting bit 10 drives the acknowledge output high whatever the core state. A restart input returns a halted core to normal running.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: In the run state, a high `halt_req_i` moves the block to the drain state on the next edge. On that same edge, status bits [5:2] load the code 4'b0100.
- R2: In the drain state, once the outstanding count is zero the barrier completes. On the next edge `dbg_ack_o`, `cpu_done_o` and status bit 0 (halted) all rise.
- R3: `cpu_done_o` never rises while any access issued before entry is still outstanding.
- R4: An issue accepted while `issue_ok_o` is high raises the outstanding count by one. A completion lowers it by one, and both in the same cycle leave it unchanged. A completion when the count is zero is ignored.
- R5: `issue_ok_o` is low in every state other than run, and also while the count is at its maximum (15 by default). An issue made while it is low is not counted.
- R6: A debugger write (`dbg_wr_i`) loads bit 10 of the write data into status bit 10 on the next edge. `dbg_ack_o` is high whenever the core is halted or status bit 10 is set.
- R7: Only status bit 10 is writable. Writes to every other bit are ignored. Bits [5:2] and bit 0 are set only by hardware, and all other bits read 0.
- R8: A `restart_i` in the halted state returns the block to run on the next edge. It clears `cpu_done_o`, the halted bit and status bit 10, except that a write in the same cycle sets bit 10. A `restart_i` in any other state is ignored.
- R9: The requester keeps `halt_req_i` high until `dbg_ack_o` is high. Dropping it earlier is an illegal stimulus.
- R10: After reset the status register is 0, `dbg_ack_o` and `cpu_done_o` are low, and `issue_ok_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req_i | input | 1 | External halt request |
| restart_i | input | 1 | Restart from halted state |
| mem_issue_i | input | 1 | Core issues a memory access |
| mem_cmpl_i | input | 1 | One outstanding memory access completes |
| dbg_wr_i | input | 1 | Debugger write strobe for the status register |
| dbg_wdata_i | input | STAT_W | Debugger write data |
| issue_ok_o | output | 1 | Core may issue a memory access this cycle |
| dbg_ack_o | output | 1 | Debug acknowledge |
| cpu_done_o | output | 1 | Barrier complete and no outstanding accesses |
| status_o | output | STAT_W | Debug status register |

## Verification
The embedded assertions check the following on every cycle:
- the counter never overflows and never decrements below zero;
- no issue is accepted outside the run state;
- done implies acknowledge;
- done only rises after a cycle with a zero count;
- the entry code is loaded on every entry;
- debugger writes land in bit 10 one edge later.

Only the directed scenarios can show the following:
- the exact edge on which done rises after the last completion;
- that issues blocked during drain leave no trace in the count;
- that restart outside the halted state and writes to read-only bits change nothing visible;
- that the requester honours the hold rule.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_HALTED = 2'd2
  } dbg_state_e;

  // entry-method code for an external halt request
  localparam logic [3:0] ENTRY_EXT_HALT = 4'b0100;

  // status register field positions
  localparam int BIT_HALTED = 0;
  localparam int CODE_LO    = 2;
  localparam int BIT_SWACK  = 10;

  // next outstanding count: +1 on accepted issue, -1 on completion unless empty
  function automatic int unsigned cnt_step(int unsigned cnt, logic inc, logic dec);
    int unsigned r;
    r = cnt + (inc ? 1 : 0);
    if (dec && cnt != 0) r = r - 1;
    return r;
  endfunction

endpackage

// File: rtl/dbg_access_tracker.sv
module dbg_access_tracker
  import dbg_halt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_i,
  input  logic cmpl_i,
  input  logic run_nxt_i,
  output logic issue_ok_o,
  output logic accept_o,
  output logic cnt_zero_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             ok_q;

  assign accept_o   = issue_i & ok_q;
  assign cnt_nxt    = CNT_W'(cnt_step(32'(cnt_q), accept_o, cmpl_i));
  assign cnt_zero_o = (cnt_q == '0);
  assign issue_ok_o = ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ok_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      ok_q  <= run_nxt_i && (cnt_nxt != CNT_MAX);
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> (cnt_q != CNT_MAX));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && cmpl_i && !accept_o) |=> (cnt_q == '0));

  // R4
  balanced_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && cmpl_i) |=> $stable(cnt_q));

endmodule

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
  import dbg_halt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req_i,
  input  logic       restart_i,
  input  logic       cnt_zero_i,
  input  logic       sw_ack_nxt_i,
  output dbg_state_e state_o,
  output logic       run_nxt_o,
  output logic       halted_nxt_o,
  output logic       entry_evt_o,
  output logic       barrier_done_o,
  output logic       restart_evt_o,
  output logic       ack_o,
  output logic       done_o
);

  dbg_state_e state_q, state_nxt;
  logic       ack_q, done_q;

  assign entry_evt_o    = (state_q == ST_RUN) && halt_req_i;
  assign barrier_done_o = (state_q == ST_DRAIN) && cnt_zero_i;
  assign restart_evt_o  = (state_q == ST_HALTED) && restart_i;

  always_comb begin
    state_nxt = state_q;
    if (entry_evt_o)         state_nxt = ST_DRAIN;
    else if (barrier_done_o) state_nxt = ST_HALTED;
    else if (restart_evt_o)  state_nxt = ST_RUN;
  end

  assign run_nxt_o    = (state_nxt == ST_RUN);
  assign halted_nxt_o = (state_nxt == ST_HALTED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      ack_q   <= halted_nxt_o | sw_ack_nxt_i;
      done_q  <= halted_nxt_o;
    end
  end

  assign state_o = state_q;
  assign ack_o   = ack_q;
  assign done_o  = done_q;

  // R2
  done_implies_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ack_q);

  // R8
  restart_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt_o |=> (state_q == ST_RUN && !done_q));

  // R1
  entry_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_evt_o |=> (state_q == ST_DRAIN));

  // R2
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 2'd3);

endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
  import dbg_halt_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic              entry_evt_i,
  input  logic              restart_evt_i,
  input  logic              halted_nxt_i,
  output logic              sw_ack_nxt_o,
  output logic [STAT_W-1:0] status_o
);

  localparam logic [STAT_W-1:0] WR_MASK = STAT_W'(1) << BIT_SWACK;

  logic [3:0]        code_q;
  logic              halted_q;
  logic              swack_q;
  logic [STAT_W-1:0] wr_bits;

  assign wr_bits = wdata_i & WR_MASK;

  always_comb begin
    if (wr_i)               sw_ack_nxt_o = |wr_bits;
    else if (restart_evt_i) sw_ack_nxt_o = 1'b0;
    else                    sw_ack_nxt_o = swack_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      halted_q <= 1'b0;
      swack_q  <= 1'b0;
    end else begin
      if (entry_evt_i) code_q <= ENTRY_EXT_HALT;
      halted_q <= halted_nxt_i;
      swack_q  <= sw_ack_nxt_o;
    end
  end

  always_comb begin
    status_o = '0;
    status_o[BIT_HALTED]          = halted_q;
    status_o[CODE_LO+3:CODE_LO]   = code_q;
    status_o[BIT_SWACK]           = swack_q;
  end

  // R1
  entry_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_evt_i |=> (status_o[CODE_LO+3:CODE_LO] == ENTRY_EXT_HALT));

  // R6
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (status_o[BIT_SWACK] == $past(wdata_i[BIT_SWACK])));

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_req_i,
  input  logic              restart_i,
  input  logic              mem_issue_i,
  input  logic              mem_cmpl_i,
  input  logic              dbg_wr_i,
  input  logic [STAT_W-1:0] dbg_wdata_i,
  output logic              issue_ok_o,
  output logic              dbg_ack_o,
  output logic              cpu_done_o,
  output logic [STAT_W-1:0] status_o
);

  dbg_state_e state;
  logic run_nxt, halted_nxt, entry_evt, barrier_done, restart_evt;
  logic accept, cnt_zero, sw_ack_nxt;

  dbg_access_tracker #(.CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (mem_issue_i),
    .cmpl_i     (mem_cmpl_i),
    .run_nxt_i  (run_nxt),
    .issue_ok_o (issue_ok_o),
    .accept_o   (accept),
    .cnt_zero_o (cnt_zero)
  );

  dbg_entry_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .halt_req_i     (halt_req_i),
    .restart_i      (restart_i),
    .cnt_zero_i     (cnt_zero),
    .sw_ack_nxt_i   (sw_ack_nxt),
    .state_o        (state),
    .run_nxt_o      (run_nxt),
    .halted_nxt_o   (halted_nxt),
    .entry_evt_o    (entry_evt),
    .barrier_done_o (barrier_done),
    .restart_evt_o  (restart_evt),
    .ack_o          (dbg_ack_o),
    .done_o         (cpu_done_o)
  );

  dbg_status_reg #(.STAT_W(STAT_W)) u_stat (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_i          (dbg_wr_i),
    .wdata_i       (dbg_wdata_i),
    .entry_evt_i   (entry_evt),
    .restart_evt_i (restart_evt),
    .halted_nxt_i  (halted_nxt),
    .sw_ack_nxt_o  (sw_ack_nxt),
    .status_o      (status_o)
  );

  // R5
  issue_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN) |-> !accept);

  // R3
  done_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_done_o) |-> $past(barrier_done));

  // R6
  swack_drives_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[BIT_SWACK] |-> dbg_ack_o);

  // R2
  halted_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[BIT_HALTED] == cpu_done_o);

endmodule

// File: tb/tb_dbg_halt_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_halt_ctrl;

  localparam int STAT_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 1'b0, restart = 1'b0, iss = 1'b0, cmp = 1'b0, wr = 1'b0;
  logic [STAT_W-1:0] wdat = '0;
  logic issue_ok, ack, done;
  logic [STAT_W-1:0] status;

  int errors = 0;
  int checks = 0;
  int illegal_drops = 0;
  bit finished = 1'b0;
  logic prev_req = 1'b0;

  always #2.5 clk = ~clk;

  dbg_halt_ctrl #(.CNT_W(4), .STAT_W(STAT_W)) dut (
    .clk(clk), .rst_n(rst_n), .halt_req_i(halt_req), .restart_i(restart),
    .mem_issue_i(iss), .mem_cmpl_i(cmp), .dbg_wr_i(wr), .dbg_wdata_i(wdat),
    .issue_ok_o(issue_ok), .dbg_ack_o(ack), .cpu_done_o(done), .status_o(status)
  );

  // R9 monitor: request dropped before acknowledge is illegal stimulus
  always @(negedge clk) begin
    if (rst_n && prev_req && !halt_req && !ack) illegal_drops++;
    prev_req <= halt_req;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_restart();
    halt_req = 1'b0;
    restart = 1'b1;
    step(1);
    restart = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 status", status, 32'h0);
    chk("R10 ack", {31'b0, ack}, 0);
    chk("R10 done", {31'b0, done}, 0);
    chk("R10 issue_ok", {31'b0, issue_ok}, 1);
  endtask

  task automatic t_quick_halt();
    halt_req = 1'b1;
    step(1);
    chk("R1 code", {28'b0, status[5:2]}, 4'b0100);
    chk("R5 issue_ok in drain", {31'b0, issue_ok}, 0);
    chk("R2 ack not yet", {31'b0, ack}, 0);
    step(1);
    chk("R2 ack", {31'b0, ack}, 1);
    chk("R2 done", {31'b0, done}, 1);
    chk("R2 halted bit", {31'b0, status[0]}, 1);
    do_restart();
    chk("R8 ack cleared", {31'b0, ack}, 0);
    chk("R8 done cleared", {31'b0, done}, 0);
    chk("R8 halted cleared", {31'b0, status[0]}, 0);
    chk("R8 issue_ok back", {31'b0, issue_ok}, 1);
  endtask

  task automatic t_drain();
    iss = 1'b1; step(3); iss = 1'b0;
    halt_req = 1'b1; step(1);
    iss = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(1);
      chk("R3 done held low while outstanding", {31'b0, done}, 0);
    end
    iss = 1'b0;
    cmp = 1'b1; step(2); cmp = 1'b0; step(1);
    chk("R3 one outstanding", {31'b0, done}, 0);
    cmp = 1'b1; step(1); cmp = 1'b0;
    chk("R2 barrier edge pending", {31'b0, done}, 0);
    step(1);
    chk("R5 blocked issues not counted, done", {31'b0, done}, 1);
    chk("R2 ack after drain", {31'b0, ack}, 1);
    do_restart();
  endtask

  task automatic t_count_rules();
    iss = 1'b1; step(1);
    cmp = 1'b1; step(3);
    iss = 1'b0; step(1);
    step(2);
    cmp = 1'b0;
    iss = 1'b1; halt_req = 1'b1; step(1);
    iss = 1'b0;
    step(3);
    chk("R4 issue on entry edge counted", {31'b0, done}, 0);
    cmp = 1'b1; step(1); cmp = 1'b0;
    chk("R4 count zero, barrier pending", {31'b0, done}, 0);
    step(1);
    chk("R4 done after last completion", {31'b0, done}, 1);
    do_restart();
  endtask

  task automatic t_saturate();
    iss = 1'b1; step(20); iss = 1'b0;
    chk("R5 issue_ok low at max", {31'b0, issue_ok}, 0);
    halt_req = 1'b1; step(1);
    cmp = 1'b1; step(14); cmp = 1'b0; step(2);
    chk("R3 done low with one left", {31'b0, done}, 0);
    cmp = 1'b1; step(1); cmp = 1'b0; step(1);
    chk("R5 exactly 15 counted", {31'b0, done}, 1);
    do_restart();
    chk("R5 issue_ok after restart", {31'b0, issue_ok}, 1);
  endtask

  task automatic t_swack();
    wr = 1'b1; wdat = '1; step(1); wr = 1'b0; wdat = '0;
    chk("R6 sw ack drives ack", {31'b0, ack}, 1);
    chk("R7 only bit 10 writable", status, 32'h410);
    chk("R6 done stays low", {31'b0, done}, 0);
    chk("R6 issue_ok stays high", {31'b0, issue_ok}, 1);
    restart = 1'b1; step(1); restart = 1'b0;
    chk("R8 restart ignored in run", status, 32'h410);
    chk("R8 ack unchanged in run", {31'b0, ack}, 1);
    wr = 1'b1; step(1); wr = 1'b0;
    chk("R6 clear sw ack", {31'b0, ack}, 0);
    chk("R7 status after clear", status, 32'h010);
    halt_req = 1'b1; step(2);
    halt_req = 1'b0;
    wr = 1'b1; wdat = 32'h400; step(1); wr = 1'b0; wdat = '0;
    restart = 1'b1; step(1); restart = 1'b0;
    chk("R8 restart clears sw ack", {31'b0, ack}, 0);
    chk("R8 status after restart", status, 32'h010);
    halt_req = 1'b1; step(2);
    halt_req = 1'b0;
    restart = 1'b1; wr = 1'b1; wdat = 32'h400; step(1);
    restart = 1'b0; wr = 1'b0; wdat = '0;
    chk("R8 write wins over restart", {31'b0, ack}, 1);
    chk("R8 done cleared with write", {31'b0, done}, 0);
    chk("R8 status write wins", status, 32'h410);
    wr = 1'b1; step(1); wr = 1'b0;
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_quick_halt();
    t_drain();
    t_count_rules();
    t_saturate();
    t_swack();
    chk("R9 halt request held until ack", illegal_drops, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule